// File: doc/BRIEF.md
# Asynchronous SRAM Host Port

This block is the clocked front end of a 16-bit memory that presents the pin behaviour of an asynchronous static RAM. The host drives the active-low select, output-enable, write-enable and two byte-lane enables. It also drives an active-low busy line, a supply-low flag, an address and write data. A fast internal clock samples all of these through a synchronizer. The block then works out whether the cycle is a read, a write or a deselect, and drives a simple memory port with per-lane write masks. It also returns read data with a separate output-enable for each byte lane, so the pad ring can build the tri-state data bus.

Writes take effect when the write ends, on the rising edge of whichever of select or write-enable closes it. The address and data used are the ones sampled in the last cycle the write was still open. A write lockout guards against spurious writes. After reset, and after any nonvolatile transfer reported on `nv_done`, a write that is already being held does nothing until the block sees a fresh falling edge of select or write-enable. For every read that starts and every write it commits, the port emits a one-cycle access record carrying the address and the access type, for a downstream command-sequence detector. The access record has no ready input, so the consumer must accept a record in every cycle. The memory port is likewise one-way: the array must complete a write in the cycle after `mem_we` and return read data combinationally from `mem_addr`.

Top module: `sram_host_port`

## Requirements
- R1: With select low, output-enable low, write-enable high and busy high, the word at the addressed location is returned on `dq_out`, and `dq_oe` is raised for each byte lane that is enabled.
- R2: With select high, `dq_oe` is 0 and no write or access record is produced, whatever the other inputs are. After reset, `dq_oe`, `mem_we` and `acc_valid` are 0.
- R3: A write needs select and write-enable low and busy high, whatever the state of output-enable. It is committed once, when select or write-enable rises, and it uses the address and data from the last open cycle.
- R4: `be_n[1]` (active low) gates data bits 15:8 and `be_n[0]` gates bits 7:0. This holds for the lane write mask (`mem_be[i]` is set when lane i is written) and for the lane drive enables `dq_oe[i]`.
- R5: While write-enable is low, `dq_oe` is 0 even when output-enable is also low.
- R6: After reset, a write held with select and write-enable already low commits nothing. A later falling edge of write-enable or select re-enables writes.
- R7: A pulse on `nv_done` re-arms the same lockout. A write open at that moment, or held through it, commits nothing until a fresh falling edge is seen.
- R8: While `supply_low` is high, no write is committed. A write open when it rises is dropped, and the lockout is re-armed.
- R9: With busy low, no read drives the bus and no write commits. A write open when busy falls is dropped.
- R10: `acc_valid` pulses for one cycle on each read start, on each address change during a read, and on each committed write. It comes with `acc_write` (1 means a write) and `acc_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rst_n | input | 1 | Active-low reset (power-up) |
| ce_n | input | 1 | Select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| be_n | input | NB (2) | Byte-lane enables, active low; bit 1 = high byte |
| busy_n | input | 1 | Busy line, low while a transfer is in progress |
| supply_low | input | 1 | Supply-low condition, active high |
| nv_done | input | 1 | One-cycle pulse at the end of a store or recall |
| addr | input | AW | Word address |
| dq_in | input | DW | Write data from the pads |
| dq_out | output | DW | Read data to the pads |
| dq_oe | output | NB | Per-lane pad drive enable |
| mem_we | output | 1 | Memory write strobe |
| mem_be | output | NB | Memory lane write mask, active high |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, combinational from `mem_addr` |
| acc_valid | output | 1 | Access record valid, one cycle |
| acc_write | output | 1 | Access record type: 1 write, 0 read |
| acc_addr | output | AW | Access record address |

## Verification
Every pin change first passes through SYNC_STAGES (2) flops. Counting the rising edges after an input changes, `mem_we` and the access record appear after the third edge. `dq_out` and `dq_oe` follow after the fourth. The bench changes inputs on falling edges and holds each state for at least six cycles before it samples on a falling edge, so every result has settled. Each check of something that must not happen is read back at the ports: either a later read of the location the write would have hit, or the access-record counters, in both cases once the full latency has passed.

// File: rtl/sram_host_pkg.sv
package sram_host_pkg;

  // Synchronized control pins; every field is active low so reset = all ones.
  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
    logic busy_n;
    logic pwr_ok_n_inv; // 1 when supply is good
  } hp_ctl_t;

  localparam int HP_CTL_W = $bits(hp_ctl_t);

  typedef enum logic [1:0] {
    HP_IDLE    = 2'd0,
    HP_READ    = 2'd1,
    HP_WRITE   = 2'd2,
    HP_BLOCKED = 2'd3
  } hp_mode_e;

endpackage

// File: rtl/hp_sync.sv
module hp_sync #(
  parameter int           W       = 8,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         vld
);

  logic [W-1:0]      chain_q [STAGES];
  logic [STAGES-1:0] fill_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q[s] <= RST_VAL;
        fill_q[s]  <= 1'b0;
      end else begin
        chain_q[s] <= (s == 0) ? d : chain_q[(s == 0) ? 0 : s-1];
        fill_q[s]  <= (s == 0) ? 1'b1 : fill_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign q   = chain_q[STAGES-1];
  assign vld = fill_q[STAGES-1];

endmodule

// File: rtl/hp_decode.sv
module hp_decode
  import sram_host_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 16,
  localparam int NB = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  hp_ctl_t       ctl,
  input  logic [NB-1:0] be_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          nv_done,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  output logic [NB-1:0] rd_be_n,
  output logic          commit,
  output logic [AW-1:0] cm_addr,
  output logic [DW-1:0] cm_data,
  output logic [NB-1:0] cm_be_n,
  output logic          acc_valid,
  output logic          acc_write,
  output logic [AW-1:0] acc_addr
);

  hp_ctl_t       prv_q;
  logic          prv_vld_q;
  logic [AW-1:0] prv_addr_q;
  logic          armed_q, wr_open_q, rd_open_q;
  logic [AW-1:0] cap_addr_q;
  logic [DW-1:0] cap_data_q;
  logic [NB-1:0] cap_be_n_q;
  hp_mode_e      mode;
  logic          fell_ce, fell_we, rose_ce, rose_we;
  logic          wr_now, rd_now, rd_start;

  // Edges only count once the previous sample holds real pin data.
  assign fell_ce = prv_vld_q &  prv_q.ce_n & ~ctl.ce_n;
  assign fell_we = prv_vld_q &  prv_q.we_n & ~ctl.we_n;
  assign rose_ce = prv_vld_q & ~prv_q.ce_n &  ctl.ce_n;
  assign rose_we = prv_vld_q & ~prv_q.we_n &  ctl.we_n;

  always_comb begin
    if (!prv_vld_q || ctl.ce_n) begin
      mode = HP_IDLE;
    end else if (!ctl.we_n) begin
      if (ctl.busy_n && ctl.pwr_ok_n_inv && !nv_done &&
          (armed_q || fell_ce || fell_we))
        mode = HP_WRITE;
      else
        mode = HP_BLOCKED;
    end else if (!ctl.oe_n && ctl.busy_n) begin
      mode = HP_READ;
    end else begin
      mode = HP_IDLE;
    end
  end

  assign wr_now   = (mode == HP_WRITE);
  assign rd_now   = (mode == HP_READ);
  assign rd_start = rd_now & (~rd_open_q | (addr != prv_addr_q));

  // A write lands only on the rising edge that ends it, with conditions still good.
  assign commit = wr_open_q & ~wr_now & (rose_ce | rose_we) & armed_q &
                  ctl.busy_n & ctl.pwr_ok_n_inv & ~nv_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prv_q      <= '1;
      prv_vld_q  <= 1'b0;
      prv_addr_q <= '0;
      wr_open_q  <= 1'b0;
      rd_open_q  <= 1'b0;
    end else begin
      prv_q      <= ctl;
      prv_vld_q  <= in_vld;
      prv_addr_q <= addr;
      wr_open_q  <= wr_now;
      rd_open_q  <= rd_now;
    end
  end

  // Write lockout: cleared by reset, transfer end or low supply; set by a fresh edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               armed_q <= 1'b0;
    else if (nv_done || !ctl.pwr_ok_n_inv)    armed_q <= 1'b0;
    else if (fell_ce || fell_we)              armed_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_addr_q <= '0;
      cap_data_q <= '0;
      cap_be_n_q <= '1;
    end else if (wr_now) begin
      cap_addr_q <= addr;
      cap_data_q <= wdata;
      cap_be_n_q <= be_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_valid <= 1'b0;
      acc_write <= 1'b0;
      acc_addr  <= '0;
    end else begin
      acc_valid <= commit | rd_start;
      acc_write <= commit;
      acc_addr  <= commit ? cap_addr_q : addr;
    end
  end

  assign rd_req  = rd_now;
  assign rd_addr = addr;
  assign rd_be_n = be_n;
  assign cm_addr = cap_addr_q;
  assign cm_data = cap_data_q;
  assign cm_be_n = cap_be_n_q;

  p_commit_after_low_pins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> ($past(!ctl.we_n) && $past(!ctl.ce_n)));

  p_nv_blocks_next_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    nv_done |=> !commit);

  p_low_supply_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!ctl.pwr_ok_n_inv) |-> !commit);

  p_write_record_from_commit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write) |-> $past(commit));

  p_write_flag_needs_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    acc_write |-> acc_valid);

endmodule

// File: rtl/hp_bus.sv
module hp_bus #(
  parameter int AW = 10,
  parameter int DW = 16,
  localparam int NB = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_req,
  input  logic [AW-1:0] rd_addr,
  input  logic [NB-1:0] rd_be_n,
  input  logic          commit,
  input  logic [AW-1:0] cm_addr,
  input  logic [DW-1:0] cm_data,
  input  logic [NB-1:0] cm_be_n,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_we,
  output logic [NB-1:0] mem_be,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic [DW-1:0] dq_out,
  output logic [NB-1:0] dq_oe
);

  logic          rd_d1_q;
  logic [NB-1:0] rd_be_n_d1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_we       <= 1'b0;
      mem_be       <= '0;
      mem_addr     <= '0;
      mem_wdata    <= '0;
      rd_d1_q      <= 1'b0;
      rd_be_n_d1_q <= '1;
    end else begin
      mem_we       <= commit;
      mem_be       <= commit ? ~cm_be_n : '0;
      mem_addr     <= commit ? cm_addr : rd_addr;
      mem_wdata    <= cm_data;
      rd_d1_q      <= rd_req & ~commit; // array port busy with the write
      rd_be_n_d1_q <= rd_be_n;
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dq_oe[b]          <= 1'b0;
        dq_out[b*8 +: 8]  <= '0;
      end else begin
        dq_oe[b]          <= rd_d1_q & ~rd_be_n_d1_q[b];
        dq_out[b*8 +: 8]  <= mem_rdata[b*8 +: 8];
      end
    end
  end

  p_single_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  p_no_drive_beside_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mem_we) |-> (dq_oe == '0));

endmodule

// File: rtl/sram_host_port.sv
module sram_host_port
  import sram_host_pkg::*;
#(
  parameter int AW          = 10,
  parameter int DW          = 16,
  parameter int SYNC_STAGES = 2,
  localparam int NB = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [NB-1:0] be_n,
  input  logic          busy_n,
  input  logic          supply_low,
  input  logic          nv_done,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] dq_in,
  output logic [DW-1:0] dq_out,
  output logic [NB-1:0] dq_oe,
  output logic          mem_we,
  output logic [NB-1:0] mem_be,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          acc_valid,
  output logic          acc_write,
  output logic [AW-1:0] acc_addr
);

  localparam int CW = HP_CTL_W + NB;
  localparam int XW = AW + DW;

  logic [CW-1:0] ctl_raw, ctl_s;
  logic [XW-1:0] dat_raw, dat_s;
  logic          ctl_vld, dat_vld;
  hp_ctl_t       ctl;
  logic [NB-1:0] be_n_s;

  logic          rd_req, commit;
  logic [AW-1:0] rd_addr, cm_addr;
  logic [NB-1:0] rd_be_n, cm_be_n;
  logic [DW-1:0] cm_data;

  assign ctl_raw = {ce_n, oe_n, we_n, busy_n, ~supply_low, be_n};
  assign dat_raw = {addr, dq_in};

  hp_sync #(.W(CW), .STAGES(SYNC_STAGES), .RST_VAL({CW{1'b1}})) u_sync_ctl (
    .clk(clk), .rst_n(rst_n), .d(ctl_raw), .q(ctl_s), .vld(ctl_vld));

  hp_sync #(.W(XW), .STAGES(SYNC_STAGES), .RST_VAL({XW{1'b0}})) u_sync_dat (
    .clk(clk), .rst_n(rst_n), .d(dat_raw), .q(dat_s), .vld(dat_vld));

  assign ctl    = hp_ctl_t'(ctl_s[CW-1:NB]);
  assign be_n_s = ctl_s[NB-1:0];

  hp_decode #(.AW(AW), .DW(DW)) u_decode (
    .clk(clk), .rst_n(rst_n), .in_vld(ctl_vld & dat_vld), .ctl(ctl),
    .be_n(be_n_s), .addr(dat_s[XW-1:DW]), .wdata(dat_s[DW-1:0]),
    .nv_done(nv_done), .rd_req(rd_req), .rd_addr(rd_addr), .rd_be_n(rd_be_n),
    .commit(commit), .cm_addr(cm_addr), .cm_data(cm_data), .cm_be_n(cm_be_n),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr));

  hp_bus #(.AW(AW), .DW(DW)) u_bus (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_be_n(rd_be_n), .commit(commit), .cm_addr(cm_addr), .cm_data(cm_data),
    .cm_be_n(cm_be_n), .mem_rdata(mem_rdata), .mem_we(mem_we), .mem_be(mem_be),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .dq_out(dq_out), .dq_oe(dq_oe));

  p_deselect_no_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ce_n, 4) && $past(ce_n, 3) && $past(ce_n, 2)) |-> (dq_oe == '0));

endmodule

// File: tb/sim_sram_host_port.sv
`timescale 1ns/100ps
module sim_sram_host_port;

  localparam int AW = 10;
  localparam int DW = 16;
  localparam int NB = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, busy_n = 1'b1;
  logic          supply_low = 1'b0, nv_done = 1'b0;
  logic [NB-1:0] be_n = '0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dq_in = '0;
  logic [DW-1:0] dq_out, mem_wdata, mem_rdata;
  logic [NB-1:0] dq_oe, mem_be;
  logic          mem_we, acc_valid, acc_write;
  logic [AW-1:0] mem_addr, acc_addr;

  int n_chk = 0, n_fail = 0;
  int n_accr = 0, n_accw = 0;
  logic [AW-1:0] last_acc = '0;

  always #2.5 clk = ~clk;

  sram_host_port #(.AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .be_n(be_n),
    .busy_n(busy_n), .supply_low(supply_low), .nv_done(nv_done), .addr(addr),
    .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe), .mem_we(mem_we), .mem_be(mem_be),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr));

  // Behavioural array.
  logic [DW-1:0] mem [1 << AW];
  always @(posedge clk) begin
    if (mem_we && mem_be[0]) mem[mem_addr][7:0]  <= mem_wdata[7:0];
    if (mem_we && mem_be[1]) mem[mem_addr][15:8] <= mem_wdata[15:8];
  end
  assign mem_rdata = mem[mem_addr];

  always @(posedge clk) begin
    if (rst_n && acc_valid) begin
      if (acc_write) n_accw <= n_accw + 1;
      else           n_accr <= n_accr + 1;
      last_acc <= acc_addr;
    end
  end

  // Vector: [31:30] op (0 write ended by we, 1 write ended by ce, 2 read check),
  // [29] oe_n during write, [28:27] be_n, [25:16] addr, [15:0] data / expected.
  localparam int NV = 13;
  localparam logic [31:0] VEC [NV] = '{
    {2'd0, 1'b1, 2'b00, 11'h010, 16'hA55A},
    {2'd2, 1'b1, 2'b00, 11'h010, 16'hA55A},
    {2'd1, 1'b1, 2'b00, 11'h020, 16'h1234},
    {2'd2, 1'b1, 2'b00, 11'h020, 16'h1234},
    {2'd0, 1'b1, 2'b01, 11'h010, 16'hFFFF},
    {2'd2, 1'b1, 2'b00, 11'h010, 16'hFF5A},
    {2'd1, 1'b1, 2'b10, 11'h020, 16'h0000},
    {2'd2, 1'b1, 2'b00, 11'h020, 16'h1200},
    {2'd2, 1'b1, 2'b10, 11'h010, 16'hFF5A},
    {2'd2, 1'b1, 2'b01, 11'h020, 16'h1200},
    {2'd2, 1'b1, 2'b11, 11'h010, 16'hFF5A},
    {2'd0, 1'b0, 2'b00, 11'h030, 16'hBEEF},
    {2'd2, 1'b1, 2'b00, 11'h030, 16'hBEEF}
  };

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_we(input logic [AW-1:0] a, input logic [15:0] d,
                       input logic [1:0] be, input logic oe);
    addr = a; dq_in = d; be_n = be; oe_n = oe; we_n = 1'b1;
    ce_n = 1'b0; cyc(6);
    we_n = 1'b0; cyc(6);
    chk("R5 no drive while we low", {30'd0, dq_oe}, 32'd0);
    we_n = 1'b1; cyc(6);
    ce_n = 1'b1; oe_n = 1'b1; cyc(6);
  endtask

  task automatic wr_ce(input logic [AW-1:0] a, input logic [15:0] d, input logic [1:0] be);
    addr = a; dq_in = d; be_n = be;
    we_n = 1'b0; cyc(4);
    ce_n = 1'b0; cyc(6);
    ce_n = 1'b1; cyc(6);
    we_n = 1'b1; cyc(4);
  endtask

  task automatic rd_chk(input string req, input logic [AW-1:0] a, input logic [1:0] be,
                        input logic [15:0] exp);
    logic [15:0] mask;
    mask = {{8{~be[1]}}, {8{~be[0]}}};
    addr = a; be_n = be; we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
    cyc(6);
    chk({req, " lane enables"}, {30'd0, dq_oe}, {30'd0, ~be});
    chk({req, " data"}, {16'd0, dq_out & mask}, {16'd0, exp & mask});
    ce_n = 1'b1; oe_n = 1'b1; cyc(4);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cyc(5); rst_n = 1'b1; cyc(4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int r0, w0;
    cyc(3);
    chk("R2 reset dq_oe", {30'd0, dq_oe}, 32'd0);
    chk("R2 reset mem_we", {31'd0, mem_we}, 32'd0);
    chk("R2 reset acc_valid", {31'd0, acc_valid}, 32'd0);
    do_reset();

    // R1 R3 R4 R5: vector walk
    for (int i = 0; i < NV; i++) begin
      logic [31:0] v;
      v = VEC[i];
      case (v[31:30])
        2'd0: wr_we(v[25:16], v[15:0], v[28:27], v[29]);
        2'd1: wr_ce(v[25:16], v[15:0], v[28:27]);
        default: rd_chk("R1 R4 vector read", v[25:16], v[28:27], v[15:0]);
      endcase
    end

    // R2: deselected with oe low gives no drive and no records
    r0 = n_accr; w0 = n_accw;
    addr = 10'h010; oe_n = 1'b0; we_n = 1'b1; ce_n = 1'b1; cyc(8);
    chk("R2 deselect dq_oe", {30'd0, dq_oe}, 32'd0);
    we_n = 1'b0; cyc(4); we_n = 1'b1; cyc(6); oe_n = 1'b1;
    chk("R2 deselect no records", n_accr + n_accw, r0 + w0);

    // R10: read with two address changes gives three read records
    r0 = n_accr; w0 = n_accw;
    be_n = 2'b00; addr = 10'h011; oe_n = 1'b0; ce_n = 1'b0; cyc(5);
    addr = 10'h012; cyc(5);
    addr = 10'h013; cyc(5);
    ce_n = 1'b1; oe_n = 1'b1; cyc(5);
    chk("R10 read record count", n_accr - r0, 3);
    chk("R10 last read address", {22'd0, last_acc}, 32'h013);
    wr_ce(10'h044, 16'h0F0F, 2'b00);
    chk("R10 write record count", n_accw - w0, 1);
    chk("R10 write record address", {22'd0, last_acc}, 32'h044);

    // R6: write held low across reset is locked out
    wr_ce(10'h040, 16'h2222, 2'b00);
    addr = 10'h040; dq_in = 16'h1111; ce_n = 1'b0; we_n = 1'b0;
    do_reset(); cyc(4);
    we_n = 1'b1; cyc(6); ce_n = 1'b1; cyc(4);
    rd_chk("R6 held write ignored", 10'h040, 2'b00, 16'h2222);
    addr = 10'h040; dq_in = 16'h1111; ce_n = 1'b0; we_n = 1'b0; cyc(6);
    we_n = 1'b1; cyc(6); ce_n = 1'b1; cyc(4);
    rd_chk("R6 fresh edge writes", 10'h040, 2'b00, 16'h1111);

    // R7: nv_done re-arms the lockout for an open write
    wr_ce(10'h050, 16'h4444, 2'b00);
    addr = 10'h050; dq_in = 16'h3333; ce_n = 1'b0; cyc(4); we_n = 1'b0; cyc(6);
    nv_done = 1'b1; cyc(1); nv_done = 1'b0; cyc(4);
    we_n = 1'b1; cyc(6); ce_n = 1'b1; cyc(4);
    rd_chk("R7 write after transfer ignored", 10'h050, 2'b00, 16'h4444);

    // R8: supply low drops an open write and blocks new ones
    addr = 10'h050; dq_in = 16'h5555; ce_n = 1'b0; cyc(4); we_n = 1'b0; cyc(6);
    supply_low = 1'b1; cyc(6); we_n = 1'b1; cyc(6);
    we_n = 1'b0; cyc(6); we_n = 1'b1; cyc(6); ce_n = 1'b1; supply_low = 1'b0; cyc(6);
    rd_chk("R8 supply low write ignored", 10'h050, 2'b00, 16'h4444);

    // R9: busy blocks reads and writes
    busy_n = 1'b0; addr = 10'h050; be_n = 2'b00; ce_n = 1'b0; oe_n = 1'b0; cyc(6);
    chk("R9 busy read no drive", {30'd0, dq_oe}, 32'd0);
    oe_n = 1'b1; ce_n = 1'b1; cyc(4);
    dq_in = 16'h6666; ce_n = 1'b0; cyc(2); we_n = 1'b0; cyc(6); we_n = 1'b1; cyc(6);
    ce_n = 1'b1; busy_n = 1'b1; cyc(6);
    rd_chk("R9 busy write ignored", 10'h050, 2'b00, 16'h4444);

    // R3: writes work again after the blocked cases
    wr_we(10'h050, 16'h7777, 2'b00, 1'b1);
    rd_chk("R3 write after recovery", 10'h050, 2'b00, 16'h7777);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule